// File: doc/BRIEF.md
# Restoring Array Divider

This block divides one unsigned integer by another in a single pass of combinational logic. It is built as a stack of identical rows, one per quotient bit. Each row takes the partial remainder from the row above, shifts it left by one place while shifting in the next dividend bit, and tries to subtract the divisor. The row's borrow decides the quotient bit. If the subtraction does not borrow, the difference moves down as the new partial remainder. If it borrows, the shifted value moves down unchanged.

The first row works on the most significant dividend bit and starts from a partial remainder of zero. The last row works on bit zero, and its output is the final remainder. A small guard stage spots a zero divisor and makes the output well defined in that case. The block holds no state and has no clock, so it fits in a register-to-register path of a datapath that needs one quotient and one remainder per operation.

Top module: `restoringDivider`

## Requirements
- R1: For a nonzero divisor, `quotient` equals the integer part of `dividend / divisor`, with both operands taken as unsigned `WIDTH`-bit numbers.
- R2: For a nonzero divisor, `remainder` equals `dividend mod divisor`, so it is always strictly less than `divisor`.
- R3: For every operand pair with a nonzero divisor, `quotient * divisor + remainder` equals `dividend` exactly, computed at twice the width.
- R4: When `divisor` is zero, `quotient` is all ones and `remainder` equals `dividend`.
- R5: Quotient bits are decided from the most significant down. Row k (k = 0 at the top) decides quotient bit WIDTH-1-k and uses dividend bit WIDTH-1-k. So a dividend smaller than the divisor gives quotient 0 and remainder equal to the dividend, and a dividend equal to the divisor gives quotient 1 and remainder 0.
- R6: The outputs depend only on the present inputs. Applying an operand pair again after other pairs gives the same result.
- R7: The same structure is correct for every `WIDTH`. This is shown at 4 bits over every operand pair and at 8 bits over random pairs plus the extreme values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | WIDTH | Unsigned numerator |
| divisor | input | WIDTH | Unsigned denominator; zero is allowed |
| quotient | output | WIDTH | Unsigned integer quotient |
| remainder | output | WIDTH | Unsigned remainder |

## Verification
The block has no registers, so every result is due in the same cycle as the operands that produce it: zero clock edges pass between stimulus and answer. The bench drives a pair, waits a short fixed delay so the rows settle, and only then samples the quotient and the remainder. It never waits for a clock edge. Expected values come from the bench's own division and modulo arithmetic. The zero-divisor case is compared against the all-ones quotient and the pass-through remainder.

// File: rtl/divPkg.sv
package divPkg;

  // Strobes sent from the divisor guard to the row datapath
  typedef struct packed {
    logic forceOnes;     // drive the quotient to all ones
    logic passDividend;  // drive the remainder to the raw dividend
  } divStrobes_t;

endpackage

// File: rtl/divRow.sv
// One subtract-and-select step of restoring division.
module divRow #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] remIn,
  input  logic             dividendBit,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] remOut,
  output logic             quotBit
);

  localparam int TRIAL_W = WIDTH + 1;
  localparam int DIFF_W  = WIDTH + 2;

  logic [TRIAL_W-1:0] trial;
  logic [DIFF_W-1:0]  diffWide;
  logic               borrow;

  always_comb begin
    trial    = {remIn, dividendBit};
    diffWide = {1'b0, trial} - {2'b00, divisor};
    borrow   = diffWide[DIFF_W-1];
    quotBit  = ~borrow;
    remOut   = quotBit ? diffWide[WIDTH-1:0] : trial[WIDTH-1:0];
  end

  // Whichever value moves down to the next row must fit in WIDTH bits.
  always_comb begin
    if (quotBit) begin
      AST_ROW_DIFF_FITS: assert (diffWide[WIDTH] == 1'b0); // R2
    end else begin
      AST_ROW_TRIAL_FITS: assert (trial[WIDTH] == 1'b0); // R2
    end
    if (divisor != '0) begin
      AST_ROW_REM_BOUND: assert (remOut < divisor); // R2
    end
  end

endmodule

// File: rtl/divGuard.sv
// Control side: works out the output strobes from the divisor.
module divGuard
  import divPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] divisor,
  output divStrobes_t      strobes
);

  logic zeroDivisor;

  always_comb begin
    zeroDivisor          = (divisor == '0);
    strobes.forceOnes    = zeroDivisor;
    strobes.passDividend = zeroDivisor;
  end

endmodule

// File: rtl/divArray.sv
// Datapath side: WIDTH rows chained from the MSB down, then output select.
module divArray
  import divPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  divStrobes_t      strobes,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  localparam int ROWS   = WIDTH;
  localparam int PROD_W = 2 * WIDTH;

  logic [ROWS:0][WIDTH-1:0] remChain;
  logic [WIDTH-1:0]         rawQuot;

  assign remChain[0] = '0;

  for (genvar r = 0; r < ROWS; r++) begin : gRow
    localparam int BIT = WIDTH - 1 - r;  // R5: the top row handles the MSB
    divRow #(.WIDTH(WIDTH)) uRow (
      .remIn       (remChain[r]),
      .dividendBit (dividend[BIT]),
      .divisor     (divisor),
      .remOut      (remChain[r+1]),
      .quotBit     (rawQuot[BIT])
    );
  end

  always_comb begin
    quotient  = strobes.forceOnes    ? '1       : rawQuot;
    remainder = strobes.passDividend ? dividend : remChain[ROWS];
  end

  logic [PROD_W-1:0] rebuilt;
  always_comb begin
    rebuilt = {{WIDTH{1'b0}}, quotient} * {{WIDTH{1'b0}}, divisor}
            + {{WIDTH{1'b0}}, remainder};
    if (divisor != '0) begin
      AST_RECONSTRUCT: assert (rebuilt == {{WIDTH{1'b0}}, dividend}); // R3
      AST_REM_BELOW_DIVISOR: assert (remainder < divisor); // R2
    end else begin
      AST_ZERO_QUOT_ONES: assert (&quotient); // R4
      AST_ZERO_REM_PASS: assert (remainder == dividend); // R4
    end
  end

endmodule

// File: rtl/restoringDivider.sv
module restoringDivider
  import divPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  divStrobes_t strobes;

  divGuard #(.WIDTH(WIDTH)) uGuard (
    .divisor (divisor),
    .strobes (strobes)
  );

  divArray #(.WIDTH(WIDTH)) uArray (
    .dividend  (dividend),
    .divisor   (divisor),
    .strobes   (strobes),
    .quotient  (quotient),
    .remainder (remainder)
  );

endmodule

// File: tb/tb_restoringDivider.sv
module tb_restoringDivider;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int WW = 8;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NW-1:0] aN, bN, qN, rN;
  logic [WW-1:0] aW, bW, qW, rW;

  restoringDivider #(.WIDTH(NW)) dut (
    .dividend(aN), .divisor(bN), .quotient(qN), .remainder(rN));
  restoringDivider #(.WIDTH(WW)) dutWide (
    .dividend(aW), .divisor(bW), .quotient(qW), .remainder(rW));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic checkVal(input string req, input string what,
                          input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected values computed here from R1, R2, R4
  task automatic runNarrow(input int a, input int b, input string req);
    int expQ, expR;
    aN = NW'(a); bN = NW'(b);
    #1;
    if (b == 0) begin expQ = (1 << NW) - 1; expR = a; end
    else begin expQ = a / b; expR = a % b; end
    checkVal(req, "quotient", int'(qN), expQ);
    checkVal(req, "remainder", int'(rN), expR);
    if (b != 0) checkVal("R3", "q*b+r", int'(qN) * b + int'(rN), a);
  endtask

  task automatic runWide(input int a, input int b, input string req);
    int expQ, expR;
    aW = WW'(a); bW = WW'(b);
    #1;
    if (b == 0) begin expQ = (1 << WW) - 1; expR = a; end
    else begin expQ = a / b; expR = a % b; end
    checkVal(req, "wide quotient", int'(qW), expQ);
    checkVal(req, "wide remainder", int'(rW), expR);
    if (b != 0) checkVal("R3", "wide q*b+r", int'(qW) * b + int'(rW), a);
  endtask

  initial begin
    aN = '0; bN = '0; aW = '0; bW = '0;
    #2;
    // Zero inputs: R4 gives all ones and a zero remainder
    checkVal("R4", "initial quotient", int'(qN), (1 << NW) - 1);
    checkVal("R4", "initial remainder", int'(rN), 0);

    // R7 / R1 / R2: every 4-bit pair
    for (int a = 0; a < (1 << NW); a++)
      for (int b = 0; b < (1 << NW); b++)
        runNarrow(a, b, (b == 0) ? "R4" : "R1_R2_R7");

    // R5 boundaries: MSB-first decisions
    runNarrow(13, 2, "R5");   // 6 rem 1
    runNarrow(3, 9, "R5");    // dividend below divisor
    runNarrow(9, 9, "R5");    // equal
    runNarrow(15, 1, "R5");
    runNarrow(8, 15, "R5");

    // R4 at the wide size
    runWide(0, 0, "R4");
    runWide(200, 0, "R4");
    runWide(255, 0, "R4");
    // R7 wide extremes
    runWide(255, 255, "R5");
    runWide(255, 1, "R7");
    runWide(128, 127, "R7");
    runWide(1, 255, "R5");
    for (int k = 0; k < 2000; k++)
      runWide(int'($urandom_range(255)), int'($urandom_range(255)), "R1_R2_R7");

    // R6: no memory of earlier operands
    runNarrow(14, 4, "R6");
    runNarrow(7, 0, "R6");
    runNarrow(14, 4, "R6");
    runWide(77, 5, "R6");
    runWide(250, 3, "R6");
    runWide(77, 5, "R6");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule